// File: doc/BRIEF.md
# Stream-Detecting Hardware Data Prefetcher

This block watches last-level cache misses and turns sequential miss patterns into prefetch requests that run ahead of demand. Each miss carries a byte address, a load/store flag and a two-bit memory type. The block keeps a small table of stream entries, and each entry owns one aligned 4 KB region. A region's entry becomes a trained stream when two successive misses land within a trigger distance of each other. The sign of that confirming stride fixes the stream direction.

A trained stream issues one 64-byte line per request. It never issues the same line twice and never leaves its region. It stays at most a fixed number of lines (by default 4 lines, 256 bytes) beyond the latest demand miss of the stream. Streams confirmed by a store ask for ownership reads, and streams confirmed by a load ask for plain data reads. When a miss opens a new region and the table is full, the least recently touched entry is replaced.

The miss input is a valid-only port. The block takes a miss on every cycle that `miss_valid` is high and never stalls it. The request output is valid/ready. A request is transferred on a cycle where `pf_valid` and `pf_ready` are both high. While `pf_ready` is low, the pending request holds its address and kind. A new request loads only when the output is empty or is being transferred. When several streams are eligible, the lowest entry index wins.

Top module: `stream_prefetcher`

## Requirements
- R1: A region becomes a trained stream only after two successive cacheable misses in it whose line stride d satisfies 0 < |d| < TRIG_LINES (default 4 lines). A first miss, a repeated line or a larger stride produces no request.
- R2: A trained stream issues one line per request, at consecutive line addresses. It issues only lines at most AHEAD_LINES (default 4) beyond the most recent demand line of that stream. After a confirming miss on line L going forward, lines L+1..L+4 are issued.
- R3: A line already issued for a stream is never issued again. A later miss inside the issued window only lets the window advance by the newly allowed lines.
- R4: Each aligned 4 KB region has at most one entry, and loads and stores share it. Up to NUM_STREAMS (default 8) regions are tracked at once.
- R5: A miss in an untracked region, with all entries in use, replaces the entry touched least recently.
- R6: No request leaves the stream's 4 KB region. Issuing stops at line 63 going forward and at line 0 going backward.
- R7: A miss with memory type 2 (write-combining) or 3 (uncacheable) is ignored: it neither allocates, trains nor extends a stream. Types 0 (write-back) and 1 (write-through) are cacheable.
- R8: `pf_rfo` is 1 for requests of a stream whose confirming miss was a store, and 0 for one confirmed by a load.
- R9: A positive confirming stride gives ascending request addresses, and a negative one gives descending addresses. The direction stays fixed until the entry is replaced.
- R10: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid`, `pf_addr` and `pf_rfo` stay unchanged on the next cycle.
- R11: Synchronous reset invalidates all entries and drops any pending request, so `pf_valid` is 0 after reset. A miss after reset in a previously trained region only allocates an entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_is_store | input | 1 | 1 for a store miss, 0 for a load miss |
| miss_mtype | input | 2 | Memory type: 0 write-back, 1 write-through, 2 write-combining, 3 uncacheable |
| pf_valid | output | 1 | A prefetch request is pending |
| pf_ready | input | 1 | Downstream takes the request this cycle |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |
| pf_rfo | output | 1 | 1 for an ownership read, 0 for a data read |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 8 entries, a trigger distance of 4 lines and a lead of 4 lines. With 8 entries, a full table and an eviction are reached with nine regions. With a 4-line lead, an approach to the page edge from line 60 or 61 shows truncation after a few requests. A stride of 7 lines lies outside the trigger window, which makes the training rejection visible. Holding `pf_ready` low while a stream is trained exercises the hold rule. A reset asserted in that state exercises the drop of the pending request.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    MT_WB = 2'd0,
    MT_WT = 2'd1,
    MT_WC = 2'd2,
    MT_UC = 2'd3
  } mem_type_e;

  function automatic logic is_cacheable(mem_type_e mt);
    return (mt == MT_WB) || (mt == MT_WT);
  endfunction
endpackage

// File: rtl/pf_stream_entry.sv
module pf_stream_entry #(
  parameter int TAG_W       = 20,
  parameter int LINE_W      = 6,
  parameter int TRIG_LINES  = 4,
  parameter int AHEAD_LINES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_i,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              store_i,
  input  logic              adv_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              elig_o,
  output logic [LINE_W-1:0] next_o,
  output logic              rfo_o
);
  localparam int SW = LINE_W + 2;
  localparam logic signed [SW-1:0] ONE_S   = SW'(1);
  localparam logic signed [SW-1:0] TRIG_S  = SW'(TRIG_LINES);
  localparam logic signed [SW-1:0] AHEAD_S = SW'(AHEAD_LINES);
  localparam logic signed [SW-1:0] MAXL_S  = SW'((1 << LINE_W) - 1);

  logic                     valid_q, trained_q, back_q, store_q;
  logic [TAG_W-1:0]         tag_q;
  logic [LINE_W-1:0]        last_q;
  logic signed [SW-1:0]     next_q;
  logic signed [SW-1:0]     line_s, last_s, diff, mag, lead;
  logic                     confirm, in_page;

  always_comb begin
    line_s  = signed'({2'b00, line_i});
    last_s  = signed'({2'b00, last_q});
    diff    = line_s - last_s;
    mag     = diff[SW-1] ? -diff : diff;
    confirm = (diff != '0) && (mag < TRIG_S);
    lead    = back_q ? (last_s - next_q) : (next_q - last_s);
    in_page = !next_q[SW-1] && (next_q <= MAXL_S);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      trained_q <= 1'b0;
      back_q    <= 1'b0;
      store_q   <= 1'b0;
      tag_q     <= '0;
      last_q    <= '0;
      next_q    <= '0;
    end else if (upd_i) begin
      last_q <= line_i;
      if (alloc_i) begin
        valid_q   <= 1'b1;
        trained_q <= 1'b0;
        tag_q     <= tag_i;
        store_q   <= store_i;
      end else if (!trained_q) begin
        store_q <= store_i;
        if (confirm) begin
          trained_q <= 1'b1;
          back_q    <= diff[SW-1];
          next_q    <= diff[SW-1] ? (line_s - ONE_S) : (line_s + ONE_S);
        end
      end else if (!back_q && (next_q <= line_s)) begin
        next_q <= line_s + ONE_S;
      end else if (back_q && (next_q >= line_s)) begin
        next_q <= line_s - ONE_S;
      end
    end else if (adv_i) begin
      next_q <= back_q ? (next_q - ONE_S) : (next_q + ONE_S);
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign elig_o  = valid_q && trained_q && in_page && (lead <= AHEAD_S);
  assign next_o  = next_q[LINE_W-1:0];
  assign rfo_o   = store_q;

  // R6
  adv_legal_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |-> (elig_o && !upd_i));

  // R9
  dir_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (trained_q && !(upd_i && alloc_i)) |=> (back_q == $past(back_q)));
endmodule

// File: rtl/pf_lru.sv
module pf_lru #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [N-1:0]     valid_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [N-1:0][IDX_W-1:0] age_q;
  logic [N-1:0]            oldest;
  logic [IDX_W-1:0]        age_old;

  assign age_old = age_q[touch_idx_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i) age_q[i] <= '0;
        else if (age_q[i] < age_old)   age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++) oldest[i] = (age_q[i] == IDX_W'(N - 1));
    for (int i = N - 1; i >= 0; i--) if (oldest[i]) victim_o = IDX_W'(i);
    for (int i = N - 1; i >= 0; i--) if (!valid_i[i]) victim_o = IDX_W'(i);
  end

  // R5
  lru_perm_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(oldest));
endmodule

// File: rtl/pf_issue.sv
module pf_issue #(
  parameter int N      = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 6,
  parameter int OFF_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N-1:0]             elig_i,
  input  logic [N-1:0][TAG_W-1:0]  tag_i,
  input  logic [N-1:0][LINE_W-1:0] next_i,
  input  logic [N-1:0]             rfo_i,
  input  logic                     ready_i,
  output logic [N-1:0]             adv_o,
  output logic                     valid_o,
  output logic [ADDR_W-1:0]        addr_o,
  output logic                     rfo_o
);
  logic [IDX_W-1:0] sel;
  logic             any, load;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) if (elig_i[i]) sel = IDX_W'(i);
    any   = |elig_i;
    load  = !valid_o || ready_i;
    adv_o = '0;
    if (load && any) adv_o[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      rfo_o   <= 1'b0;
    end else if (load) begin
      valid_o <= any;
      if (any) begin
        addr_o <= {tag_i[sel], next_i[sel], {OFF_W{1'b0}}};
        rfo_o  <= rfo_i[sel];
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(rfo_o)));

  // R2
  one_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(adv_o));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !valid_o);
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import pf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_STREAMS = 8,
  parameter int LINE_BYTES  = 64,
  parameter int PAGE_BYTES  = 4096,
  parameter int TRIG_LINES  = 4,
  parameter int AHEAD_LINES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_is_store,
  input  logic [1:0]        miss_mtype,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              pf_rfo
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int PG_W   = $clog2(PAGE_BYTES);
  localparam int LINE_W = PG_W - OFF_W;
  localparam int TAG_W  = ADDR_W - PG_W;
  localparam int IDX_W  = $clog2(NUM_STREAMS);

  mem_type_e                         mtype;
  logic                              cacheable, act, hit_any;
  logic [TAG_W-1:0]                  miss_tag;
  logic [LINE_W-1:0]                 miss_line;
  logic                              offs_unused;
  logic [NUM_STREAMS-1:0]            valid_m, hit_m, upd_m, elig_m, adv_m, rfo_m;
  logic [NUM_STREAMS-1:0][TAG_W-1:0]  tag_m;
  logic [NUM_STREAMS-1:0][LINE_W-1:0] next_m;
  logic [IDX_W-1:0]                  hit_idx, victim, tgt;

  assign mtype       = mem_type_e'(miss_mtype);
  assign cacheable   = is_cacheable(mtype);
  assign act         = miss_valid && cacheable;
  assign miss_tag    = miss_addr[ADDR_W-1:PG_W];
  assign miss_line   = miss_addr[PG_W-1:OFF_W];
  assign offs_unused = ^miss_addr[OFF_W-1:0];

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_STREAMS; i++) hit_m[i] = valid_m[i] && (tag_m[i] == miss_tag);
    for (int i = NUM_STREAMS - 1; i >= 0; i--) if (hit_m[i]) hit_idx = IDX_W'(i);
    hit_any = |hit_m;
    tgt     = hit_any ? hit_idx : victim;
    upd_m   = '0;
    if (act) upd_m[tgt] = 1'b1;
  end

  pf_lru #(.N(NUM_STREAMS), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst(rst), .touch_i(act), .touch_idx_i(tgt),
    .valid_i(valid_m), .victim_o(victim)
  );

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_ent
    logic elig_raw;
    pf_stream_entry #(
      .TAG_W(TAG_W), .LINE_W(LINE_W),
      .TRIG_LINES(TRIG_LINES), .AHEAD_LINES(AHEAD_LINES)
    ) u_ent (
      .clk(clk), .rst(rst), .upd_i(upd_m[g]), .alloc_i(!hit_any),
      .tag_i(miss_tag), .line_i(miss_line), .store_i(miss_is_store),
      .adv_i(adv_m[g]), .valid_o(valid_m[g]), .tag_o(tag_m[g]),
      .elig_o(elig_raw), .next_o(next_m[g]), .rfo_o(rfo_m[g])
    );
    assign elig_m[g] = elig_raw && !upd_m[g];
  end

  pf_issue #(
    .N(NUM_STREAMS), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .LINE_W(LINE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_issue (
    .clk(clk), .rst(rst), .elig_i(elig_m), .tag_i(tag_m), .next_i(next_m),
    .rfo_i(rfo_m), .ready_i(pf_ready), .adv_o(adv_m),
    .valid_o(pf_valid), .addr_o(pf_addr), .rfo_o(pf_rfo)
  );

  // R4
  one_region_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_m));

  // R7
  uncached_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !cacheable) |=> $stable(valid_m));
endmodule

// File: tb/stream_prefetcher_tb.sv
module stream_prefetcher_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] addr;
    logic        st;
    logic [1:0]  mt;
    logic [3:0]  cnt;
    logic [31:0] first;
    logic [31:0] last;
    logic        rfo;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{"R1 ", 32'h1000_0100, 1'b0, 2'd0, 4'd0, 32'h0, 32'h0, 1'b0},
    '{"R2 ", 32'h1000_0140, 1'b0, 2'd0, 4'd4, 32'h1000_0180, 32'h1000_0240, 1'b0},
    '{"R3 ", 32'h1000_0180, 1'b0, 2'd0, 4'd1, 32'h1000_0280, 32'h1000_0280, 1'b0},
    '{"R8 ", 32'h2000_0800, 1'b1, 2'd0, 4'd0, 32'h0, 32'h0, 1'b0},
    '{"R9 ", 32'h2000_07C0, 1'b1, 2'd0, 4'd4, 32'h2000_0780, 32'h2000_06C0, 1'b1},
    '{"R7 ", 32'h3000_0000, 1'b0, 2'd3, 4'd0, 32'h0, 32'h0, 1'b0},
    '{"R7 ", 32'h3000_0040, 1'b0, 2'd1, 4'd0, 32'h0, 32'h0, 1'b0},
    '{"R1 ", 32'h3000_0200, 1'b0, 2'd0, 4'd0, 32'h0, 32'h0, 1'b0},
    '{"R1 ", 32'h3000_0240, 1'b0, 2'd0, 4'd4, 32'h3000_0280, 32'h3000_0340, 1'b0},
    '{"R6 ", 32'h4000_0F80, 1'b0, 2'd0, 4'd0, 32'h0, 32'h0, 1'b0},
    '{"R6 ", 32'h4000_0FC0, 1'b0, 2'd0, 4'd0, 32'h0, 32'h0, 1'b0},
    '{"R6 ", 32'h5000_0F00, 1'b0, 2'd0, 4'd0, 32'h0, 32'h0, 1'b0},
    '{"R6 ", 32'h5000_0F40, 1'b0, 2'd0, 4'd2, 32'h5000_0F80, 32'h5000_0FC0, 1'b0},
    '{"R7 ", 32'h6000_0000, 1'b0, 2'd2, 4'd0, 32'h0, 32'h0, 1'b0},
    '{"R7 ", 32'h6000_0040, 1'b0, 2'd2, 4'd0, 32'h0, 32'h0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        miss_is_store = 1'b0;
  logic [1:0]  miss_mtype = '0;
  logic        pf_ready = 1'b1;
  logic        pf_valid, pf_rfo;
  logic [31:0] pf_addr;

  int nchk = 0;
  int nfail = 0;
  int nlog = 0;
  bit done = 0;
  logic [31:0] log_addr [256];
  logic        log_rfo  [256];

  stream_prefetcher u_dut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_is_store(miss_is_store), .miss_mtype(miss_mtype),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_rfo(pf_rfo)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && pf_valid && pf_ready && nlog < 256) begin
      log_addr[nlog] = pf_addr;
      log_rfo[nlog]  = pf_rfo;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_miss(input logic [31:0] a, input logic st, input logic [1:0] mt);
    @(posedge clk); #1;
    miss_valid = 1'b1; miss_addr = a; miss_is_store = st; miss_mtype = mt;
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic expect_new(input int base, input int cnt, input string tag);
    chk(nlog - base == cnt, tag, 32'(nlog - base), 32'(cnt));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int base;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R11: empty output after reset
    chk(pf_valid == 1'b0, "R11 reset", 32'(pf_valid), 32'h0);

    for (int v = 0; v < NV; v++) begin
      base = nlog;
      send_miss(VECS[v].addr, VECS[v].st, VECS[v].mt);
      idle(10);
      chk(nlog - base == int'(VECS[v].cnt), string'(VECS[v].tag), 32'(nlog - base), 32'(VECS[v].cnt));
      if (VECS[v].cnt != 0 && nlog - base == int'(VECS[v].cnt)) begin
        chk(log_addr[base] == VECS[v].first, string'(VECS[v].tag), log_addr[base], VECS[v].first);
        chk(log_addr[nlog-1] == VECS[v].last, string'(VECS[v].tag), log_addr[nlog-1], VECS[v].last);
        // R8: request kind follows the confirming access
        chk(log_rfo[base] == VECS[v].rfo, "R8 kind", 32'(log_rfo[base]), 32'(VECS[v].rfo));
      end
    end

    // R5 and R4: fill eight regions, touch the first, then evict
    do_reset();
    for (int i = 0; i < 8; i++) send_miss(32'h7000_0000 + 32'(i) * 32'h1000, 1'b0, 2'd0);
    base = nlog;
    send_miss(32'h7000_0040, 1'b0, 2'd0);
    idle(10);
    expect_new(base, 4, "R4 eight regions held");
    send_miss(32'h7000_8000, 1'b0, 2'd0);
    idle(4);
    base = nlog;
    send_miss(32'h7000_3040, 1'b0, 2'd0);
    idle(10);
    expect_new(base, 4, "R5 younger entry kept");
    base = nlog;
    send_miss(32'h7000_1040, 1'b0, 2'd0);
    idle(10);
    expect_new(base, 0, "R5 oldest entry replaced");

    // R10: hold under back-pressure
    do_reset();
    pf_ready = 1'b0;
    send_miss(32'h8000_0000, 1'b0, 2'd0);
    send_miss(32'h8000_0040, 1'b0, 2'd0);
    idle(3);
    chk(pf_valid == 1'b1, "R10 pending", 32'(pf_valid), 32'h1);
    chk(pf_addr == 32'h8000_0080, "R10 addr", pf_addr, 32'h8000_0080);
    idle(5);
    chk(pf_valid == 1'b1 && pf_addr == 32'h8000_0080, "R10 held", pf_addr, 32'h8000_0080);
    base = nlog;
    pf_ready = 1'b1;
    idle(10);
    expect_new(base, 4, "R10 drained");
    if (nlog - base == 4) begin
      chk(log_addr[base] == 32'h8000_0080, "R3 first", log_addr[base], 32'h8000_0080);
      chk(log_addr[base+3] == 32'h8000_0140, "R2 lead", log_addr[base+3], 32'h8000_0140);
    end

    // R11: reset drops pending request and the trained entry
    pf_ready = 1'b0;
    send_miss(32'h9000_0000, 1'b0, 2'd0);
    send_miss(32'h9000_0040, 1'b0, 2'd0);
    idle(3);
    chk(pf_valid == 1'b1, "R11 pre pending", 32'(pf_valid), 32'h1);
    do_reset();
    chk(pf_valid == 1'b0, "R11 dropped", 32'(pf_valid), 32'h0);
    pf_ready = 1'b1;
    base = nlog;
    send_miss(32'h9000_0080, 1'b0, 2'd0);
    idle(10);
    expect_new(base, 0, "R11 entries cleared");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule